// File: doc/BRIEF.md
# MIDI Host Port with Command Acknowledge

This block places a byte-wide host register window in front of a MIDI serial link. The host sees two addresses. Address 0 is the data register. Address 1 is a shared command/status location: a write there is taken as a command, and a read there returns status. Behind the window there are two serial paths. The transmit path has one holding byte and a shifter that drives the serial output. The receive path is an oversampled receiver whose bytes land in a single receive data register. Both serial paths run from a bit clock-enable, `baud_tick`, pulsing `OSR` times per bit. With the default of 16 ticks per bit, a 500 kHz tick gives 31250 baud.

The port starts in command mode. Only two command codes do anything, and all others are dropped. 0x3F switches the port to UART mode. 0xFF flushes both serial directions and returns the port to command mode. Each of these two commands leaves the acknowledge byte 0xFE in the receive data register for the host to read.

In UART mode, bytes written to the data register are serialized as 8N1, least significant bit first. Bytes received on the serial input are delivered to the host. There is no stall signal on the host side. Back-pressure is given by status bit 6: while that bit is high, the holding byte is occupied and data writes are discarded. Status bit 7 low means a byte is waiting to be read. `irq_tx_empty` and `irq_rx_ready` are single-cycle pulses for an external interrupt controller.

Top module: `midi_host_port`

## Requirements
- R1: After reset, status reads 0x80 (bit 7 high, bit 6 low, bits 5..0 zero), `midi_txd` is high, both interrupt pulses are low, and the port is in command mode.
- R2: A write to address 1 is a command and does not alter the data register. A read from address 1 returns status and has no side effect.
- R3: Command 0x3F enters UART mode, loads 0xFE into the data register, drives status bit 7 low and pulses `irq_rx_ready` for one cycle.
- R4: Command 0xFF aborts any frame in progress so that `midi_txd` is high in the cycle after the command. It empties the holding byte, returns the port to command mode and loads the 0xFE acknowledge.
- R5: Any command code other than 0x3F and 0xFF leaves the mode, the data register and status unchanged, and produces no acknowledge.
- R6: A read of address 0 returns the data register and sets status bit 7 high.
- R7: In UART mode, a byte written to address 0 while status bit 6 is low is sent as a start bit (0), eight data bits LSB first, and a stop bit (1), each lasting `OSR` ticks.
- R8: Status bit 6 is high while the holding byte is occupied, and a data write made then is discarded. In command mode, data writes are discarded.
- R9: `irq_tx_empty` pulses for one cycle each time the holding byte moves into the shifter.
- R10: In UART mode, a correctly framed serial byte lands in the data register when status bit 7 is high, then drives bit 7 low and pulses `irq_rx_ready`.
- R11: A serial frame whose stop bit samples low is discarded, and the line must return high before a new start bit is recognised.
- R12: A serial byte that completes while status bit 7 is low is dropped, and the unread byte is kept. Serial bytes arriving in command mode are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Clock-enable, OSR pulses per serial bit |
| host_cs | input | 1 | Host access select |
| host_wr | input | 1 | Host write strobe (with host_cs) |
| host_rd | input | 1 | Host read strobe (with host_cs) |
| host_addr | input | 1 | 0 = data register, 1 = command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational on host_addr) |
| midi_txd | output | 1 | Serial output, idle high |
| midi_rxd | input | 1 | Serial input, idle high |
| irq_tx_empty | output | 1 | One-cycle pulse when the holding byte drains |
| irq_rx_ready | output | 1 | One-cycle pulse when a byte lands in the data register |

## Verification
The bench builds the port with `OSR` = 8 and holds `baud_tick` high, so each serial bit lasts eight clocks and a full frame lasts eighty. This keeps back-to-back transmit frames, a flush partway through a frame, and overrun of an unread byte within a short run. It also leaves a margin of several clocks around each mid-bit sample taken by the bench's own serial decoder and driver. The default synchroniser depth is kept, so the receive latency the bench allows for covers those stages.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_FLUSH = 8'hFF;
  localparam logic [BYTE_W-1:0] CMD_UART  = 8'h3F;
  localparam logic [BYTE_W-1:0] ACK_CODE  = 8'hFE;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  typedef enum logic [2:0] {
    RXS_IDLE,
    RXS_START,
    RXS_BITS,
    RXS_STOP,
    RXS_WAIT_HIGH
  } rx_state_e;
endpackage

// File: rtl/midi_tx.sv
module midi_tx
  import midi_port_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              txd,
  output logic              drain_pulse
);
  localparam int CW     = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int FRAME  = BYTE_W + 2;
  localparam int BCW    = $clog2(FRAME + 1);

  logic              hold_full;
  logic [BYTE_W-1:0] hold_data;
  logic              busy;
  logic [FRAME-1:0]  frame;
  logic [CW-1:0]     tick_cnt;
  logic [BCW-1:0]    bit_cnt;

  assign in_ready = !hold_full;
  assign txd      = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      hold_full   <= 1'b0;
      hold_data   <= '0;
      busy        <= 1'b0;
      frame       <= '1;
      tick_cnt    <= '0;
      bit_cnt     <= '0;
      drain_pulse <= 1'b0;
    end else begin
      drain_pulse <= 1'b0;
      if (in_valid && in_ready) begin
        hold_data <= in_data;
        hold_full <= 1'b1;
      end
      if (!busy && hold_full) begin
        frame       <= {1'b1, hold_data, 1'b0};
        busy        <= 1'b1;
        tick_cnt    <= '0;
        bit_cnt     <= '0;
        hold_full   <= 1'b0;
        drain_pulse <= 1'b1;
      end else if (busy && tick) begin
        if (tick_cnt == CW'(OSR - 1)) begin
          tick_cnt <= '0;
          if (bit_cnt == BCW'(FRAME - 1)) begin
            busy <= 1'b0;
          end else begin
            frame   <= {1'b1, frame[FRAME-1:1]};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end

  AST_HOLD_NOT_OVERWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !flush) |=> $stable(hold_data)); // R8
  AST_DRAIN_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    drain_pulse |=> !drain_pulse); // R9
endmodule

// File: rtl/midi_rx.sv
module midi_rx
  import midi_port_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              flush,
  input  logic              rxd,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  localparam int CW   = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int HALF = (OSR / 2 > 0) ? OSR / 2 - 1 : 0;
  localparam int BW   = $clog2(BYTE_W);

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  line;
  rx_state_e             state;
  logic [CW-1:0]         tick_cnt;
  logic [BW-1:0]         bit_idx;
  logic [BYTE_W-1:0]     shreg;

  genvar g;
  generate
    for (g = 0; g < SYNC_DEPTH; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else if (g == 0) sync_q[g] <= rxd;
        else sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign line = sync_q[SYNC_DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      state     <= RXS_IDLE;
      tick_cnt  <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          RXS_IDLE: begin
            tick_cnt <= '0;
            if (!line) state <= RXS_START;
          end
          RXS_START: begin
            if (tick_cnt == CW'(HALF)) begin
              tick_cnt <= '0;
              bit_idx  <= '0;
              state    <= line ? RXS_IDLE : RXS_BITS;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          RXS_BITS: begin
            if (tick_cnt == CW'(OSR - 1)) begin
              tick_cnt <= '0;
              shreg    <= {line, shreg[BYTE_W-1:1]};
              if (bit_idx == BW'(BYTE_W - 1)) state <= RXS_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          RXS_STOP: begin
            if (tick_cnt == CW'(OSR - 1)) begin
              tick_cnt <= '0;
              if (line) begin
                out_valid <= 1'b1;
                out_data  <= shreg;
                state     <= RXS_IDLE;
              end else begin
                state <= RXS_WAIT_HIGH;
              end
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          RXS_WAIT_HIGH: begin
            if (line) state <= RXS_IDLE;
          end
          default: state <= RXS_IDLE;
        endcase
      end
    end
  end

  AST_NO_BYTE_ON_FRAMING_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RXS_WAIT_HIGH) |-> !out_valid); // R11
endmodule

// File: rtl/midi_cmd_ctrl.sv
module midi_cmd_ctrl
  import midi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [BYTE_W-1:0] cmd_code,
  input  logic              data_re,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              uart_mode,
  output logic              flush,
  output logic              rx_full,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_irq
);
  logic is_flush, is_uart, accept;

  assign is_flush = (cmd_code == CMD_FLUSH);
  assign is_uart  = (cmd_code == CMD_UART);
  assign accept   = cmd_we && (is_flush || is_uart);
  assign flush    = cmd_we && is_flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uart_mode <= 1'b0;
      rx_full   <= 1'b0;
      rx_data   <= '0;
      rx_irq    <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (accept) begin
        uart_mode <= is_uart;
        rx_data   <= ACK_CODE;
        rx_full   <= 1'b1;
        rx_irq    <= 1'b1;
      end else begin
        if (data_re) rx_full <= 1'b0;
        if (rx_valid && uart_mode && !rx_full) begin
          rx_data <= rx_byte;
          rx_full <= 1'b1;
          rx_irq  <= 1'b1;
        end
      end
    end
  end

  AST_ACK_AFTER_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (cmd_code == 8'h3F || cmd_code == 8'hFF)) |=> (rx_full && rx_data == 8'hFE && rx_irq)); // R3
  AST_FLUSH_LEAVES_UART: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == 8'hFF) |=> !uart_mode); // R4
  AST_UNKNOWN_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code != 8'h3F && cmd_code != 8'hFF && !rx_valid && !data_re)
      |=> ($stable(uart_mode) && $stable(rx_data) && $stable(rx_full))); // R5
  AST_UNREAD_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !data_re && !cmd_we) |=> (rx_full && $stable(rx_data))); // R12
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
  import midi_port_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       host_cs,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       midi_txd,
  input  logic       midi_rxd,
  output logic       irq_tx_empty,
  output logic       irq_rx_ready
);
  logic              cmd_we, data_we, data_re;
  logic              uart_mode, flush;
  logic              tx_ready;
  logic              rx_valid, rx_full;
  logic [BYTE_W-1:0] rx_byte, rx_data;
  logic [BYTE_W-1:0] status;

  assign cmd_we  = host_cs && host_wr && (host_addr == ADDR_CTRL);
  assign data_we = host_cs && host_wr && (host_addr == ADDR_DATA);
  assign data_re = host_cs && host_rd && (host_addr == ADDR_DATA);

  assign status     = {!rx_full, !tx_ready, {(BYTE_W-2){1'b0}}};
  assign host_rdata = (host_addr == ADDR_CTRL) ? status : rx_data;

  midi_cmd_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_code  (host_wdata),
    .data_re   (data_re),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .uart_mode (uart_mode),
    .flush     (flush),
    .rx_full   (rx_full),
    .rx_data   (rx_data),
    .rx_irq    (irq_rx_ready)
  );

  midi_tx #(.OSR(OSR)) i_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (baud_tick),
    .flush       (flush),
    .in_valid    (data_we && uart_mode),
    .in_ready    (tx_ready),
    .in_data     (host_wdata),
    .txd         (midi_txd),
    .drain_pulse (irq_tx_empty)
  );

  midi_rx #(.OSR(OSR), .SYNC_DEPTH(SYNC_DEPTH)) i_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .flush     (flush),
    .rxd       (midi_rxd),
    .out_valid (rx_valid),
    .out_data  (rx_byte)
  );

  AST_FLUSH_IDLES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_wr && host_addr && host_wdata == 8'hFF) |=> midi_txd); // R4
endmodule

// File: tb/test_midi_host_port.sv
module test_midi_host_port;
  localparam int OSR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic txd, irq_tx, irq_rx;
  logic rxd = 1'b1;

  int n_tests = 0, n_fail = 0;
  int cnt_irq_tx = 0, cnt_irq_rx = 0;
  bit low_seen = 1'b0;

  always #5 clk = ~clk;

  midi_host_port #(.OSR(OSR)) i_midi_host_port (
    .clk(clk), .rst_n(rst_n), .baud_tick(1'b1),
    .host_cs(cs), .host_wr(wr), .host_rd(rd), .host_addr(addr),
    .host_wdata(wdata), .host_rdata(rdata),
    .midi_txd(txd), .midi_rxd(rxd),
    .irq_tx_empty(irq_tx), .irq_rx_ready(irq_rx)
  );

  always @(negedge clk) begin
    if (irq_tx) cnt_irq_tx++;
    if (irq_rx) cnt_irq_rx++;
    if (!txd) low_seen = 1'b1;
  end

  // cmd, ack expected, uart mode expected afterwards
  localparam logic [9:0] VEC [8] = '{
    {8'h3F, 1'b1, 1'b1}, {8'h00, 1'b0, 1'b1}, {8'h7E, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b0}, {8'hFE, 1'b0, 1'b0}, {8'h3E, 1'b0, 1'b0},
    {8'h3F, 1'b1, 1'b1}, {8'hFF, 1'b1, 1'b0}};

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic hread(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic get_frame(output logic [7:0] b, output logic stop);
    while (txd) @(negedge clk);
    repeat (OSR / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (OSR) @(negedge clk);
      b[i] = txd;
    end
    repeat (OSR) @(negedge clk);
    stop = txd;
  endtask

  task automatic send_serial(input logic [7:0] b, input logic stop);
    @(negedge clk); rxd = 0;
    repeat (OSR) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (OSR) @(negedge clk);
    end
    rxd = stop;
    repeat (OSR) @(negedge clk);
    rxd = 1;
    repeat (2 * OSR) @(negedge clk);
  endtask

  task automatic run_all();
    logic [7:0] v, b1, b2;
    logic s1, s2;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    hread(1, v);
    chk("R1 status", v, 8'h80);
    chk("R1 txd", txd, 1);
    chk("R1 irq", {irq_tx, irq_rx}, 0);
    low_seen = 0;
    hwrite(0, 8'h00);
    repeat (4) @(negedge clk);
    chk("R1 command mode drops data", low_seen, 0);

    // command table
    foreach (VEC[k]) begin
      c0 = cnt_irq_rx;
      hwrite(1, VEC[k][9:2]);
      hread(1, v);
      chk(VEC[k][1] ? "R3/R4 ack status" : "R5 no ack status", v[7], !VEC[k][1]);
      chk("R2 status no side effect", cnt_irq_rx - c0, VEC[k][1]);
      if (VEC[k][1]) begin
        hread(0, v);
        chk("R6 ack byte", v, 8'hFE);
        hread(1, v);
        chk("R6 bit7 after read", v[7], 1);
      end
      low_seen = 0;
      hwrite(0, 8'h55);
      repeat (4) @(negedge clk);
      chk("R5/R8 mode after command", low_seen, VEC[k][0]);
      repeat (12 * OSR) @(negedge clk);
    end

    // R7 single frame and R8/R9 back-pressure
    hwrite(1, 8'h3F); hread(0, v);
    c0 = cnt_irq_tx;
    fork
      begin
        get_frame(b1, s1);
        get_frame(b2, s2);
      end
      begin
        hwrite(0, 8'hA5);
        hwrite(0, 8'h3C);
        hwrite(0, 8'h77);
        hread(1, v);
        chk("R8 bit6 high when holding full", v[6], 1);
      end
    join
    chk("R7 frame 1 data", b1, 8'hA5);
    chk("R7 frame 1 stop", s1, 1);
    chk("R7 frame 2 data", b2, 8'h3C);
    chk("R7 frame 2 stop", s2, 1);
    low_seen = 0;
    repeat (3 * OSR) @(negedge clk);
    chk("R8 third byte discarded", low_seen, 0);
    chk("R9 two drain pulses", cnt_irq_tx - c0, 2);
    hread(1, v);
    chk("R8 bit6 low when idle", v[6], 0);

    // R10 receive, R12 overrun, R11 framing error
    c0 = cnt_irq_rx;
    send_serial(8'h6B, 1);
    hread(1, v);
    chk("R10 bit7 low", v[7], 0);
    chk("R10 irq pulse", cnt_irq_rx - c0, 1);
    send_serial(8'h12, 1);
    hread(0, v);
    chk("R12 unread byte kept", v, 8'h6B);
    hread(1, v);
    chk("R6 bit7 high after read", v[7], 1);
    c0 = cnt_irq_rx;
    send_serial(8'h81, 0);
    hread(1, v);
    chk("R11 bad stop discarded", v[7], 1);
    chk("R11 no irq", cnt_irq_rx - c0, 0);
    send_serial(8'hC3, 1);
    hread(0, v);
    chk("R11 recovers after break", v, 8'hC3);

    // R4 flush mid-frame
    hwrite(0, 8'h00);
    repeat (3 * OSR) @(negedge clk);
    @(negedge clk); cs = 1; wr = 1; addr = 1; wdata = 8'hFF;
    @(negedge clk); cs = 0; wr = 0;
    chk("R4 txd high after flush", txd, 1);
    low_seen = 0;
    repeat (12 * OSR) @(negedge clk);
    chk("R4 frame aborted", low_seen, 0);
    hread(0, v);
    chk("R4 ack byte", v, 8'hFE);
    send_serial(8'h44, 1);
    hread(1, v);
    chk("R12 command mode drops serial byte", v[7], 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule